// File: doc/BRIEF.md
# Memory Chip Select Decoder

This block turns a 16-bit processor address and its bus strobes into the active-low controls for a small memory system built from 8 KB chips. The address space is cut into eight equal 8 KB regions, chosen by the top three address bits. The bottom two regions (0000h-3FFFh) are read-only memory. The third region (4000h-5FFFh) is a hole kept free for later use. The remaining five regions (6000h-FFFFh) are RAM. Each populated region has its own chip select. The low thirteen address bits are passed on to every chip as the in-chip address.

Every select, the RAM write strobe and the shared output enable are qualified by the active-low memory request. A request that lands in the hole drives no chip at all. Instead it raises a flag that the system can turn into a bus error. By default every output is registered once, which eases timing in a fabric. A parameter removes the register and leaves a purely combinational path.

Top module: `memsel_decoder`

## Requirements
- R1: With `mreq_n` low and an address in 0000h-3FFFh, `rom_cs_n[k]` is low for k = addr[15:13] and every other select is high.
- R2: With `mreq_n` low and an address in 4000h-5FFFh, no chip select is low, `ram_we_n` and `mem_oe_n` stay high, and `resv_hit` is high.
- R3: With `mreq_n` low and an address in 6000h-FFFFh, `ram_cs_n[j]` is low for j = addr[15:13] - 3 and every other select is high.
- R4: While `mreq_n` is high, all selects, `ram_we_n` and `mem_oe_n` are high and `resv_hit` is low, whatever the address.
- R5: `ram_we_n` is low only for a valid request to a RAM address with `rd_wr_n` low (0 = write, 1 = read).
- R6: A write (`rd_wr_n` = 0) to the ROM range still selects the ROM chip, but `ram_we_n` stays high.
- R7: `mem_oe_n` is low only for a valid read (`rd_wr_n` = 1) to a ROM or RAM address.
- R8: At most one of the seven chip selects is low in any cycle.
- R9: `chip_addr` carries addr[12:0] out of reset, whether or not a request is present.
- R10: In the default registered mode, outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high, they hold the idle state: all selects and strobes high, `resv_hit` low, `chip_addr` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address A15..A0 |
| mreq_n | input | 1 | Memory request, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| rom_cs_n | output | 2 | Active-low selects, one per ROM chip |
| ram_cs_n | output | 5 | Active-low selects, one per RAM chip |
| ram_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| resv_hit | output | 1 | Valid request into the reserved hole |
| chip_addr | output | 13 | In-chip address A12..A0 |

## Verification
A wrong region decode shows up as the wrong select going low, or as two selects low together. It also shows up as a select firing in the hole or while the strobe is idle. Each of these is visible on the first registered cycle after the offending address. A wrong qualification of the write or read strobe shows up as `ram_we_n` or `mem_oe_n` moving on the wrong access type within that same cycle. The bench sweeps every region in both directions with the strobe on and off, and it covers the region edges. A random stream then follows, and a one-cycle reference model checks every output on every clock.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

  typedef enum logic [1:0] {
    KIND_ROM  = 2'd0,
    KIND_HOLE = 2'd1,
    KIND_RAM  = 2'd2
  } region_kind_e;

  // Region index -> kind, given the ROM and hole region counts (ROM lowest).
  function automatic region_kind_e kind_of(input int idx, input int rom_n, input int hole_n);
    if (idx < rom_n)               return KIND_ROM;
    else if (idx < rom_n + hole_n) return KIND_HOLE;
    else                           return KIND_RAM;
  endfunction

endpackage

// File: rtl/memsel_region_dec.sv
module memsel_region_dec #(
  parameter int SEL_W = 3,
  localparam int NREG = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic [NREG-1:0]  hit
);

  // Enabled one-hot region decode.
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = en && (sel == SEL_W'(i));
  end

endmodule

// File: rtl/memsel_select_map.sv
module memsel_select_map
  import memsel_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ROM_N  = 2,
  parameter int HOLE_N = 1,
  localparam int RAM_N = NREG - ROM_N - HOLE_N
) (
  input  logic [NREG-1:0]   hit,
  input  logic              rd_wr_n,
  output logic [ROM_N-1:0]  rom_sel,
  output logic [RAM_N-1:0]  ram_sel,
  output logic              hole,
  output logic              we,
  output logic              oe
);

  logic [HOLE_N-1:0] hole_v;

  for (genvar i = 0; i < NREG; i++) begin : g_route
    localparam region_kind_e K = kind_of(i, ROM_N, HOLE_N);
    if (K == KIND_ROM) begin : g_rom
      assign rom_sel[i] = hit[i];
    end else if (K == KIND_HOLE) begin : g_hole
      assign hole_v[i-ROM_N] = hit[i];
    end else begin : g_ram
      assign ram_sel[i-ROM_N-HOLE_N] = hit[i];
    end
  end

  logic any_rom, any_ram;
  assign any_rom = |rom_sel;
  assign any_ram = |ram_sel;
  assign hole    = |hole_v;
  // Writes only reach RAM; reads enable any populated region.
  assign we      = any_ram && !rd_wr_n;
  assign oe      = (any_rom || any_ram) && rd_wr_n;

  // R2 / R8: the hole and any chip select never coincide, at most one chip.
  always_comb begin
    assert (!(hole && (any_rom || any_ram)) && $onehot0({rom_sel, ram_sel}))
      else $error("p_excl_sel_r8");
  end

endmodule

// File: rtl/memsel_out_stage.sv
module memsel_out_stage #(
  parameter int           W       = 8,
  parameter logic [W-1:0] IDLE    = '0,
  parameter bit           REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= IDLE;
      else     q <= d;
    end
  end else begin : g_comb
    assign q = d;
  end

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder #(
  parameter int ADDR_W    = 16,
  parameter int SEL_W     = 3,
  parameter int ROM_N     = 2,
  parameter int HOLE_N    = 1,
  parameter bit REGISTER_OUT = 1'b1,
  localparam int NREG     = 1 << SEL_W,
  localparam int RAM_N    = NREG - ROM_N - HOLE_N,
  localparam int CHIP_AW  = ADDR_W - SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               mreq_n,
  input  logic               rd_wr_n,
  output logic [ROM_N-1:0]   rom_cs_n,
  output logic [RAM_N-1:0]   ram_cs_n,
  output logic               ram_we_n,
  output logic               mem_oe_n,
  output logic               resv_hit,
  output logic [CHIP_AW-1:0] chip_addr
);

  localparam int OUT_W = ROM_N + RAM_N + 3 + CHIP_AW;
  localparam logic [OUT_W-1:0] IDLE_V =
    {{ROM_N{1'b1}}, {RAM_N{1'b1}}, 1'b1, 1'b1, 1'b0, {CHIP_AW{1'b0}}};

  logic [NREG-1:0]  hit;
  logic [ROM_N-1:0] rom_sel;
  logic [RAM_N-1:0] ram_sel;
  logic             hole, we, oe;
  logic [OUT_W-1:0] nxt, cur;

  memsel_region_dec #(.SEL_W(SEL_W)) u_dec (
    .sel (addr[ADDR_W-1 -: SEL_W]),
    .en  (!mreq_n),
    .hit (hit)
  );

  memsel_select_map #(.NREG(NREG), .ROM_N(ROM_N), .HOLE_N(HOLE_N)) u_map (
    .hit     (hit),
    .rd_wr_n (rd_wr_n),
    .rom_sel (rom_sel),
    .ram_sel (ram_sel),
    .hole    (hole),
    .we      (we),
    .oe      (oe)
  );

  assign nxt = {~rom_sel, ~ram_sel, ~we, ~oe, hole, addr[CHIP_AW-1:0]};

  memsel_out_stage #(.W(OUT_W), .IDLE(IDLE_V), .REG_OUT(REGISTER_OUT)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (nxt),
    .q   (cur)
  );

  assign {rom_cs_n, ram_cs_n, ram_we_n, mem_oe_n, resv_hit, chip_addr} = cur;

  localparam logic [ADDR_W-1:0] ROM_END  = ADDR_W'(ROM_N << CHIP_AW);
  localparam logic [ADDR_W-1:0] HOLE_END = ADDR_W'((ROM_N + HOLE_N) << CHIP_AW);

  // R8: never two chips driven at once.
  property p_one_chip_r8;
    @(posedge clk) disable iff (rst) $onehot0(~{rom_cs_n, ram_cs_n});
  endproperty
  assert property (p_one_chip_r8) else $error("p_one_chip_r8");

  // R5: a write strobe always comes with exactly one RAM select and no read enable.
  property p_we_ram_only_r5;
    @(posedge clk) disable iff (rst)
      !ram_we_n |-> ($countones(~ram_cs_n) == 1 && &rom_cs_n && mem_oe_n);
  endproperty
  assert property (p_we_ram_only_r5) else $error("p_we_ram_only_r5");

  if (REGISTER_OUT) begin : g_reg_chk
    logic past_ok;
    always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
    end

    property p_idle_r4;
      @(posedge clk) disable iff (rst)
        past_ok && $past(mreq_n) |->
          (&rom_cs_n && &ram_cs_n && ram_we_n && mem_oe_n && !resv_hit);
    endproperty
    assert property (p_idle_r4) else $error("p_idle_r4");

    property p_hole_quiet_r2;
      @(posedge clk) disable iff (rst)
        past_ok && $past(!mreq_n && addr >= ROM_END && addr < HOLE_END) |->
          (resv_hit && &rom_cs_n && &ram_cs_n && ram_we_n && mem_oe_n);
    endproperty
    assert property (p_hole_quiet_r2) else $error("p_hole_quiet_r2");

    property p_rom_no_we_r6;
      @(posedge clk) disable iff (rst)
        past_ok && $past(!mreq_n && addr < ROM_END) |->
          (ram_we_n && !(&rom_cs_n) && !resv_hit);
    endproperty
    assert property (p_rom_no_we_r6) else $error("p_rom_no_we_r6");

    property p_addr_pass_r9;
      @(posedge clk) disable iff (rst)
        past_ok |-> chip_addr == $past(addr[CHIP_AW-1:0]);
    endproperty
    assert property (p_addr_pass_r9) else $error("p_addr_pass_r9");
  end

endmodule

// File: tb/memsel_decoder_tb_top.sv
`timescale 1ns/1ps
module memsel_decoder_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [15:0] addr;
  logic        mreq_n, rd_wr_n;
  logic [1:0]  rom_cs_n;
  logic [4:0]  ram_cs_n;
  logic        ram_we_n, mem_oe_n, resv_hit;
  logic [12:0] chip_addr;

  memsel_decoder dut_i (
    .clk(clk), .rst(rst), .addr(addr), .mreq_n(mreq_n), .rd_wr_n(rd_wr_n),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
    .mem_oe_n(mem_oe_n), .resv_hit(resv_hit), .chip_addr(chip_addr)
  );

  typedef struct { int a; bit m; bit r; } stim_t;
  stim_t pend[$];
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // Reference model: outputs expected one cycle after the stimulus.
  task automatic check_vec(input stim_t s);
    logic [1:0] e_rom = 2'b11;
    logic [4:0] e_ram = 5'b11111;
    logic e_we = 1'b1, e_oe = 1'b1, e_rv = 1'b0;
    string t_rom = "R1", t_ram = "R3", t_rv = "R2", t_we = "R5", t_oe = "R7";
    if (!s.m) begin
      if (s.a < 16384) begin
        e_rom[s.a / 8192] = 1'b0;
        e_oe = s.r ? 1'b0 : 1'b1;
        if (!s.r) t_we = "R6";
      end else if (s.a < 24576) begin
        e_rv = 1'b1;
      end else begin
        e_ram[(s.a - 24576) / 8192] = 1'b0;
        e_we = s.r ? 1'b1 : 1'b0;
        e_oe = s.r ? 1'b0 : 1'b1;
      end
    end else begin
      t_rom = "R4"; t_ram = "R4"; t_rv = "R4"; t_we = "R4"; t_oe = "R4";
    end
    chk(t_rom, 32'(rom_cs_n), 32'(e_rom));
    chk(t_ram, 32'(ram_cs_n), 32'(e_ram));
    chk(t_rv,  32'(resv_hit), 32'(e_rv));
    chk(t_we,  32'(ram_we_n), 32'(e_we));
    chk(t_oe,  32'(mem_oe_n), 32'(e_oe));
    chk("R9",  32'(chip_addr), 32'(s.a % 8192));
    chk("R8",  32'($countones(~{rom_cs_n, ram_cs_n}) <= 1), 32'd1);
  endtask

  task automatic step(input int a, input bit m, input bit r);
    stim_t s;
    @(negedge clk);
    if (pend.size() != 0) check_vec(pend.pop_front());
    addr = 16'(a); mreq_n = m; rd_wr_n = r;
    s.a = a; s.m = m; s.r = r;
    pend.push_back(s);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    stim_t s0;
    rst = 1'b1; addr = 16'h0123; mreq_n = 1'b0; rd_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: idle state held in reset despite an active ROM write request.
    chk("R10", 32'(rom_cs_n), 32'h3);
    chk("R10", 32'(ram_cs_n), 32'h1f);
    chk("R10", 32'(ram_we_n), 32'd1);
    chk("R10", 32'(mem_oe_n), 32'd1);
    chk("R10", 32'(resv_hit), 32'd0);
    chk("R10", 32'(chip_addr), 32'd0);
    rst = 1'b0; addr = 16'h7001; mreq_n = 1'b0; rd_wr_n = 1'b1;
    s0.a = 16'h7001; s0.m = 1'b0; s0.r = 1'b1;
    pend.push_back(s0);
    // Sweep of every region, both directions, strobe on and off (R1-R8 per region).
    for (int reg_i = 0; reg_i < 8; reg_i++)
      for (int r = 0; r < 2; r++)
        for (int m = 0; m < 2; m++)
          step(reg_i * 8192 + 16'h00a5 + reg_i * 16, bit'(m), bit'(r));
    // Region edges.
    step(16'h0000, 0, 1); step(16'h1fff, 0, 0); step(16'h2000, 0, 1);
    step(16'h3fff, 0, 0); step(16'h4000, 0, 1); step(16'h4000, 0, 0);
    step(16'h5fff, 0, 0); step(16'h6000, 0, 0); step(16'h6000, 0, 1);
    step(16'h7fff, 0, 0); step(16'hffff, 0, 0); step(16'hffff, 1, 0);
    // Random stream.
    lfsr = 16'hace1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr), lfsr[3] & lfsr[7], lfsr[5]);
    end
    @(negedge clk);
    if (pend.size() != 0) check_vec(pend.pop_front());
    done = 1'b1;
    summary();
    $finish;
  end

endmodule